// File: doc/BRIEF.md
# Byte-to-Word SRAM Bridge

This block lets an 8-bit processor bus reach an external asynchronous static RAM that is 16 bits wide and holds 256 KB. The processor presents a byte address, a read/not-write flag, a select and write data. The bridge turns each processor cycle into one word access on the memory side. The lowest byte address bit picks the byte lane. The remaining bits form the word address.

The bridge runs on a clock at twice the processor clock, so each processor cycle covers two bridge clocks. A phase flop starts at the first half after reset and then alternates. The processor holds its inputs steady for a whole cycle, and its cycles line up with the first half after reset.

The control is a three-state machine:
- `ST_IDLE` leaves the memory deselected.
- On a first-half edge with the select high, the machine moves to `ST_WRITE` (flag low) or to `ST_READ` (flag high). At that same edge it latches the word address, the lane and the write byte.
- From either access state it always returns to `ST_IDLE` on the next edge, which is the second-half edge.
- In `ST_WRITE` the bridge drives the byte onto both halves of the data bus and pulls low only the write strobe of the chosen lane.
- In `ST_READ` the bus is left undriven. The chosen byte is registered into the read-data output on the edge that leaves the state.

Top module: `byte_word_sram_bridge`

## Requirements
- R1: While reset (active high) is asserted, the memory chip select and both write strobes are high and the read-data output is 0x00.
- R2: On a write, byte address bit 0 equal to 0 pulls low only the lower-lane strobe (`mem_we_lo_n`), and bit 0 equal to 1 pulls low only the upper-lane strobe (`mem_we_hi_n`).
- R3: The two write strobes are never low at the same time.
- R4: While a write strobe is low, the data bus carries the processor byte on both bits 7..0 and bits 15..8.
- R5: The bridge drives the data bus only while a write strobe is low. A write strobe is never low without the chip select low. During a read, the chip select is low with both strobes high.
- R6: During an access, the memory address equals byte address bits 17..1 of that cycle.
- R7: A read places the selected byte (bits 7..0 for an even address, bits 15..8 for an odd one) on the read-data output by the end of the processor cycle. The output keeps its value through write and idle cycles.
- R8: A first-half edge with the select low leaves the chip select and both strobes high for the whole processor cycle.
- R9: The chip select is low for exactly one bridge clock per access, in the first half of the processor cycle, and is high again in the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock, twice the processor clock |
| rst | input | 1 | Asynchronous reset, active high |
| cpu_sel | input | 1 | Processor select for this cycle |
| cpu_addr | input | 18 | Byte address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Registered read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_lo_n | output | 1 | Lower-lane write strobe, active low |
| mem_we_hi_n | output | 1 | Upper-lane write strobe, active low |
| mem_addr | output | 17 | Memory word address |
| mem_dq | inout | 16 | Memory data bus |

## Verification
A wrong state in the machine would show at the ports within one bridge clock. Examples are a stuck access state, a mislatched lane or a lost phase. The symptom would be a strobe on the wrong lane, a chip select held low into the second half, or a strobe where the select was low.

A read-capture fault would show on the read-data output at the end of the same processor cycle. It would surface either as a wrong byte, or as a changed value after a write or idle cycle. Random reads of addresses written earlier, in both lanes and at both ends of the address space, expose lane-steering and address-slicing faults in the next read of that location.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bsb_state_e;
endpackage

// File: rtl/bsb_phase.sv
module bsb_phase (
    input  logic clk,
    input  logic rst,
    output logic first_half
);
    logic half_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    assign first_half = ~half_q;

    // R9: phase alternates every bridge clock
    p_phase_alt_r9: assert property (@(posedge clk) disable iff (rst)
        first_half |=> !first_half);
endmodule

// File: rtl/bsb_fsm.sv
module bsb_fsm
    import bsb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              first_half,
    input  logic              cpu_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              mem_ce_n,
    output logic [1:0]        lane_we_n,
    output logic [ADDR_W-2:0] word_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              lane_hi,
    output logic              bus_drive,
    output logic              capture
);
    localparam int LANES = 2;

    bsb_state_e state, state_nxt;
    logic       in_write;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (first_half && cpu_sel)
                          state_nxt = cpu_rnw ? ST_READ : ST_WRITE;
            ST_WRITE: state_nxt = ST_IDLE;
            ST_READ:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state     <= ST_IDLE;
            word_addr <= '0;
            wr_byte   <= '0;
            lane_hi   <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && first_half && cpu_sel) begin
                word_addr <= cpu_addr[ADDR_W-1:1];
                wr_byte   <= cpu_wdata;
                lane_hi   <= cpu_addr[0];
            end
        end
    end

    always_comb begin
        mem_ce_n  = 1'b1;
        in_write  = 1'b0;
        bus_drive = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WRITE: begin
                mem_ce_n  = 1'b0;
                in_write  = 1'b1;
                bus_drive = 1'b1;
            end
            ST_READ: begin
                mem_ce_n = 1'b0;
                capture  = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we_n[g] = ~(in_write && (lane_hi == (g == 1)));
    end

    // R3: never both lanes strobed
    p_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        !(lane_we_n[0] == 1'b0 && lane_we_n[1] == 1'b0));
    // R8: deselected first half keeps memory idle
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (first_half && !cpu_sel && state == ST_IDLE) |=> (mem_ce_n && lane_we_n == 2'b11));
    // R9: chip select low for one clock only
    p_ce_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |=> mem_ce_n);
    // R2: lane follows latched address bit 0
    p_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && first_half && cpu_sel && !cpu_rnw) |=>
        (lane_we_n[0] == cpu_addr[0] && lane_we_n[1] == !cpu_addr[0]));
endmodule

// File: rtl/bsb_rdlane.sv
module bsb_rdlane #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                lane_hi,
    input  logic [2*BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0]   rdata
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)          rdata <= '0;
        else if (capture) rdata <= lane_hi ? bus_in[2*BYTE_W-1:BYTE_W] : bus_in[BYTE_W-1:0];
    end

    // R7: output held when no read completes
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rdata));
endmodule

// File: rtl/byte_word_sram_bridge.sv
module byte_word_sram_bridge #(
    parameter int ADDR_W = 18,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_lo_n,
    output logic              mem_we_hi_n,
    output logic [ADDR_W-2:0] mem_addr,
    inout  wire  [2*BYTE_W-1:0] mem_dq
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              first_half;
    logic [1:0]        lane_we_n;
    logic [BYTE_W-1:0] wr_byte;
    logic              lane_hi;
    logic              bus_drive;
    logic              capture;

    bsb_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .first_half (first_half)
    );

    bsb_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .first_half (first_half),
        .cpu_sel    (cpu_sel),
        .cpu_addr   (cpu_addr),
        .cpu_rnw    (cpu_rnw),
        .cpu_wdata  (cpu_wdata),
        .mem_ce_n   (mem_ce_n),
        .lane_we_n  (lane_we_n),
        .word_addr  (mem_addr),
        .wr_byte    (wr_byte),
        .lane_hi    (lane_hi),
        .bus_drive  (bus_drive),
        .capture    (capture)
    );

    bsb_rdlane #(.BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .lane_hi (lane_hi),
        .bus_in  (mem_dq),
        .rdata   (cpu_rdata)
    );

    assign mem_we_lo_n = lane_we_n[0];
    assign mem_we_hi_n = lane_we_n[1];
    assign mem_dq      = bus_drive ? {wr_byte, wr_byte} : {WORD_W{1'bz}};

    // R5: bus driven only under an active strobe, strobe only with chip select
    p_drive_r5: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (!mem_ce_n && (!mem_we_lo_n || !mem_we_hi_n)));
    p_we_ce_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_lo_n || !mem_we_hi_n) |-> !mem_ce_n);
endmodule

// File: tb/byte_word_sram_bridge_tb.sv
module byte_word_sram_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        mem_ce_n, mem_we_lo_n, mem_we_hi_n;
    logic [16:0] mem_addr;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;

    logic [15:0] mem [int];
    logic [7:0]  ref_mem [int];
    logic [15:0] rd_val = '0;
    logic        tb_drv;
    logic [7:0]  last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_word_sram_bridge u_dut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
        .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_lo_n(mem_we_lo_n), .mem_we_hi_n(mem_we_hi_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // memory model
    assign tb_drv = !mem_ce_n && mem_we_lo_n && mem_we_hi_n;
    assign mem_dq = tb_drv ? rd_val : 16'bz;

    always @(negedge clk) begin
        logic [15:0] w;
        w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
        if (!mem_ce_n && !mem_we_lo_n) w[7:0]  = mem_dq[7:0];
        if (!mem_ce_n && !mem_we_hi_n) w[15:8] = mem_dq[15:8];
        if (!mem_ce_n && (!mem_we_lo_n || !mem_we_hi_n)) mem[int'(mem_addr)] = w;
        rd_val <= w;
    end

    function automatic logic [7:0] exp_byte(logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [16:0] exp_word(logic [17:0] a);
        return a[17:1];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one processor cycle; entered and left at a negedge before a first-half edge
    task automatic do_cycle(bit sel, bit rnw, logic [17:0] a, logic [7:0] d);
        cpu_sel = sel; cpu_rnw = rnw; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); @(negedge clk);
        if (sel && !rnw) begin
            check("R9 ce low in first half", {31'd0, mem_ce_n}, 32'd0);
            check("R2 lower strobe", {31'd0, mem_we_lo_n}, {31'd0, a[0]});
            check("R2 upper strobe", {31'd0, mem_we_hi_n}, {31'd0, !a[0]});
            check("R6 word address", {15'd0, mem_addr}, {15'd0, exp_word(a)});
            check("R4 data on both lanes", {16'd0, mem_dq}, {16'd0, d, d});
            ref_mem[int'(a)] = d;
        end else if (sel) begin
            check("R5 read ce low", {31'd0, mem_ce_n}, 32'd0);
            check("R5 read strobes high", {30'd0, mem_we_lo_n, mem_we_hi_n}, 32'd3);
            check("R6 word address", {15'd0, mem_addr}, {15'd0, exp_word(a)});
        end else begin
            check("R8 idle no access", {29'd0, mem_ce_n, mem_we_lo_n, mem_we_hi_n}, 32'd7);
        end
        @(posedge clk); @(negedge clk);
        check("R9 ce high in second half", {29'd0, mem_ce_n, mem_we_lo_n, mem_we_hi_n}, 32'd7);
        if (sel && rnw) last_rd = exp_byte(a);
        check("R7 read data", {24'd0, cpu_rdata}, {24'd0, last_rd});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset strobes", {29'd0, mem_ce_n, mem_we_lo_n, mem_we_hi_n}, 32'd7);
        check("R1 reset rdata", {24'd0, cpu_rdata}, 32'd0);
        rst = 1'b0;

        // directed corners
        do_cycle(1, 1, 18'h00000, 8'h00);          // unwritten read -> 0 (R7)
        do_cycle(1, 0, 18'h00000, 8'hA5);          // R2 lower lane
        do_cycle(1, 0, 18'h00001, 8'h3C);          // R2 upper lane, same word
        do_cycle(1, 1, 18'h00000, 8'h00);          // R7 lower byte
        do_cycle(1, 1, 18'h00001, 8'h00);          // R7 upper byte
        do_cycle(0, 0, 18'h00000, 8'hFF);          // R8 select low write ignored
        do_cycle(1, 1, 18'h00000, 8'h00);          // R8 value unchanged
        do_cycle(1, 0, 18'h3FFFF, 8'h5A);          // top byte, R6
        do_cycle(1, 0, 18'h3FFFE, 8'hC3);
        do_cycle(0, 1, 18'h3FFFF, 8'h00);          // R7 hold through idle
        do_cycle(1, 1, 18'h3FFFF, 8'h00);
        do_cycle(1, 1, 18'h3FFFE, 8'h00);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            bit          sel, rnw;
            logic [17:0] a;
            sel = ($urandom % 4) != 0;
            rnw = ($urandom % 2) != 0;
            case ($urandom % 3)
                0:       a = 18'($urandom % 32);
                1:       a = 18'h3FFE0 | 18'($urandom % 32);
                default: a = 18'($urandom);
            endcase
            do_cycle(sel, rnw, a, 8'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-all actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule